// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Handling

This block turns an asynchronous serial input line into parallel characters. It runs from a system clock together with a single-cycle enable that pulses once per oversampling tick, at sixteen ticks per bit by default. The line passes through a synchronizer first. The receiver then looks for a falling edge. It confirms the start bit with a resample half a bit later, and after that it takes one sample per bit time for the data bits, the optional parity bit and a single stop bit. The word length can be 5 to 8 bits, and parity can be odd, even or off.

Each finished character goes into a holding register, and a ready flag is raised for the host. Parity, framing and overrun flags are loaded in the same clock as the data. The line is in a break when it stays low for the whole character, stop bit included. A break gives exactly one all-zero character with the framing flag set. The receiver then stays off the line until the line has gone high again. The receiver only works while the carrier input is low and the enable input is high.

Top module: `uart_break_rx`

## Requirements
- R1: The receiver works only while `dcd_n` is 0 and `rx_en` is 1. At any other time it returns to searching for a start bit, accepts no character, and `rx_ready` reads 0 from the next clock.
- R2: The first tick that finds the synchronized line low, after a tick that found it high, begins a start bit. The line is sampled again at the 8th tick of that bit (half of OVS). If that sample is high, the receiver delivers no character and returns to the search.
- R3: After the start bit is confirmed, each later bit is sampled every OVS ticks (at its 8th tick). The order is data bits with the LSB first, then the parity bit when it is enabled, then one stop bit.
- R4: `char_len` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `rx_data` at and above the character length read 0.
- R5: When `par_en` is 1, a parity bit follows the data. With `par_odd`=1 the data bits and the parity bit must hold an odd number of ones, and with `par_odd`=0 an even number. A mismatch sets `err_parity`. When `par_en` is 0 there is no parity bit and `err_parity` reads 0.
- R6: A low stop bit on a character that is not a break sets `err_frame`, and the data bits are still delivered.
- R7: A break is a start bit, all data bits, the parity bit (if enabled) and the stop bit, all sampled low. It delivers exactly one character of 0x00 with `err_frame`=1 and `err_parity`=0. No new start bit is accepted until a tick has found the line high.
- R8: `rx_data`, `err_parity`, `err_frame` and `err_overrun` are updated in the same clock in which `rx_ready` is set. This is the clock after the tick that samples the stop bit. Between characters they hold their values.
- R9: If a character completes while `rx_ready` is still 1 and no read is strobed in that clock, `err_overrun` becomes 1 and the new character replaces the old one. A completion without this condition sets `err_overrun` to 0.
- R10: A one-cycle `rd_strobe` clears `rx_ready` in the next clock, unless a character completes in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16x | input | 1 | One-cycle oversampling enable, OVS pulses per bit |
| rxd | input | 1 | Serial input line, idle high |
| rx_en | input | 1 | Receiver enable, active high |
| dcd_n | input | 1 | Carrier detect, active low |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| rd_strobe | input | 1 | Host has taken the holding register |
| rx_data | output | 8 | Holding register, zero-extended |
| rx_ready | output | 1 | A character is waiting |
| err_parity | output | 1 | Parity error of the last character |
| err_frame | output | 1 | Framing error or break of the last character |
| err_overrun | output | 1 | Last character overwrote an unread one |

## Verification
The bench builds the receiver with OVS=16 and two synchronizer stages, and it pulses the tick once every four clocks. A bit therefore lasts 64 clocks, so a whole character finishes in well under a thousand cycles. This leaves room to run every word length, both parity senses, framing errors, a glitch shorter than half a bit, a long break, back-to-back overruns and carrier loss in one run. Because the reference model follows the same half-bit and full-bit sampling points, any change of one tick in where a sample is taken shows up as a mismatch on the outputs.

// File: rtl/rx_pkg.sv
package rx_pkg;

    localparam int RX_DW = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_WAIT
    } rx_state_e;

    typedef struct packed {
        logic [RX_DW-1:0] data;
        logic             pe;
        logic             fe;
    } rx_char_t;

    typedef struct packed {
        rx_char_t c;
        logic     ov;
        logic     ready;
    } rx_hold_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic line_o
);

    logic [STAGES-1:0] ff_d, ff_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb ff_d = rxd;
        end else begin : g_chain
            always_comb ff_d = {ff_q[STAGES-2:0], rxd};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= ff_d;
    end

    assign line_o = ff_q[STAGES-1];

endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic       active,
    input  logic [1:0] char_len,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       commit_o,
    output rx_char_t   char_o
);

    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;
    localparam logic [CW-1:0] FULL_END = CW'(OVS - 1);
    localparam logic [CW-1:0] HALF_END = CW'(HALF - 2);

    typedef struct packed {
        rx_state_e        st;
        logic [CW-1:0]    cnt;
        logic [2:0]       idx;
        logic [RX_DW-1:0] sh;
        logic             allz;
        logic             parbit;
        logic             prev;
    } frm_t;

    frm_t r_d, r_q;
    logic [2:0] last_idx;
    logic       par_exp;
    logic       brk;

    always_comb begin
        r_d      = r_q;
        commit_o = 1'b0;
        char_o   = '0;
        last_idx = 3'd4 + {1'b0, char_len};
        par_exp  = (^r_q.sh) ^ par_odd;
        brk      = r_q.allz & ~line;

        if (!active) begin
            r_d.st  = RX_IDLE;
            r_d.cnt = '0;
        end else if (tick) begin
            unique case (r_q.st)
                RX_IDLE: begin
                    if (r_q.prev && !line) begin
                        r_d.st  = RX_START;
                        r_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (r_q.cnt == HALF_END) begin
                        r_d.cnt = '0;
                        if (line) begin
                            r_d.st = RX_IDLE;
                        end else begin
                            r_d.st   = RX_DATA;
                            r_d.idx  = '0;
                            r_d.sh   = '0;
                            r_d.allz = 1'b1;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (r_q.cnt == FULL_END) begin
                        r_d.cnt          = '0;
                        r_d.sh[r_q.idx]  = line;
                        r_d.allz         = r_q.allz & ~line;
                        r_d.idx          = r_q.idx + 1'b1;
                        if (r_q.idx == last_idx)
                            r_d.st = par_en ? RX_PAR : RX_STOP;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (r_q.cnt == FULL_END) begin
                        r_d.cnt    = '0;
                        r_d.parbit = line;
                        r_d.allz   = r_q.allz & ~line;
                        r_d.st     = RX_STOP;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (r_q.cnt == FULL_END) begin
                        r_d.cnt     = '0;
                        commit_o    = 1'b1;
                        char_o.data = brk ? '0 : r_q.sh;
                        char_o.pe   = par_en & ~brk & (r_q.parbit != par_exp);
                        char_o.fe   = ~line;
                        r_d.st      = brk ? RX_WAIT : RX_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                RX_WAIT: begin
                    r_d.cnt = '0;
                    if (line) r_d.st = RX_IDLE;
                end
                default: r_d.st = RX_IDLE;
            endcase
        end

        if (tick) r_d.prev = line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= RX_IDLE;
            r_q.prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    // R3: characters complete only on an oversampling tick
    a_r3_commit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> tick);

    // R7: while waiting for idle after a break a low line never starts a bit
    a_r7_hold_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == RX_WAIT && !line) |=> r_q.st != RX_START);

    // R7: a break yields a single character, none while waiting
    a_r7_break_single: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == RX_WAIT) |-> !commit_o);

endmodule

// File: rtl/rx_holding.sv
module rx_holding
    import rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     active_i,
    input  logic     commit_i,
    input  rx_char_t char_i,
    input  logic     rd_i,
    output rx_hold_t hold_o
);

    rx_hold_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!active_i) begin
            r_d.ready = 1'b0;
        end else if (commit_i) begin
            r_d.c     = char_i;
            r_d.ov    = r_q.ready & ~rd_i;
            r_d.ready = 1'b1;
        end else if (rd_i) begin
            r_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hold_o = r_q;

    // R10: a read with no completion empties the register next cycle
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !commit_i) |=> !r_q.ready);

    // R1: an inactive receiver never shows a ready character
    a_r1_inactive_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !r_q.ready);

    // R9: overrun appears only over an unread character
    a_r9_ov_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ov) |-> $past(r_q.ready));

    // R8: ready rises only from a completed character
    a_r8_ready_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ready) |-> $past(commit_i));

endmodule

// File: rtl/uart_break_rx.sv
module uart_break_rx
    import rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_16x,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic       dcd_n,
    input  logic [1:0] char_len,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rd_strobe,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun
);

    logic     line_s;
    logic     active;
    logic     commit;
    rx_char_t chr;
    rx_hold_t hold;

    assign active = rx_en & ~dcd_n;

    rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rxd    (rxd),
        .line_o (line_s)
    );

    rx_framer #(.OVS(OVS)) i_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_16x),
        .line     (line_s),
        .active   (active),
        .char_len (char_len),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .commit_o (commit),
        .char_o   (chr)
    );

    rx_holding i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .commit_i (commit),
        .char_i   (chr),
        .rd_i     (rd_strobe),
        .hold_o   (hold)
    );

    assign rx_data     = hold.c.data;
    assign rx_ready    = hold.ready;
    assign err_parity  = hold.c.pe;
    assign err_frame   = hold.c.fe;
    assign err_overrun = hold.ov;

endmodule

// File: tb/test_uart_break_rx.sv
module test_uart_break_rx;

    localparam int OVS  = 16;
    localparam int SYNC = 2;
    localparam int TDIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic rxd = 1'b1;
    logic rx_en = 1'b1;
    logic dcd_n = 1'b0;
    logic [1:0] char_len = 2'd3;
    logic par_en = 1'b0;
    logic par_odd = 1'b0;
    logic rd = 1'b0;
    logic [7:0] rx_data;
    logic rx_ready, err_parity, err_frame, err_overrun;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int rises = 0;
    logic rdy_prev = 1'b0;
    int tcnt = 0;

    always #4 clk = ~clk;

    uart_break_rx #(.OVS(OVS), .SYNC_STAGES(SYNC)) i_uart_break_rx (
        .clk(clk), .rst_n(rst_n), .tick_16x(tick), .rxd(rxd),
        .rx_en(rx_en), .dcd_n(dcd_n), .char_len(char_len),
        .par_en(par_en), .par_odd(par_odd), .rd_strobe(rd),
        .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
        .err_frame(err_frame), .err_overrun(err_overrun)
    );

    // behavioural reference model
    logic [SYNC-1:0] m_sync = '1;
    int   m_phase = 0;
    int   m_cnt = 0;
    int   m_idx = 0;
    int   m_bits = 0;
    logic m_anyhi = 1'b0;
    logic m_pbit = 1'b0;
    logic m_prev = 1'b1;
    logic m_ready = 1'b0;
    logic [7:0] m_data = '0;
    logic m_pe = 1'b0, m_fe = 1'b0, m_ov = 1'b0;

    always @(posedge clk) begin
        logic ln, act, done, brk;
        logic [7:0] nd;
        logic npe, nfe;
        if (!rst_n) begin
            m_sync = '1; m_phase = 0; m_cnt = 0; m_prev = 1'b1;
            m_ready = 0; m_data = 0; m_pe = 0; m_fe = 0; m_ov = 0;
        end else begin
            ln = m_sync[SYNC-1];
            act = rx_en && !dcd_n;
            done = 0; nd = 0; npe = 0; nfe = 0;
            if (!act) begin
                m_phase = 0; m_cnt = 0;
            end else if (tick) begin
                if (m_phase == 0) begin
                    if (m_prev && !ln) begin m_phase = 1; m_cnt = 1; end
                end else if (m_phase == 1) begin
                    if (m_cnt == OVS/2 - 1) begin
                        m_cnt = 0;
                        if (ln) m_phase = 0;
                        else begin m_phase = 2; m_idx = 0; m_bits = 0; m_anyhi = 0; end
                    end else m_cnt++;
                end else if (m_phase == 5) begin
                    m_cnt = 0;
                    if (ln) m_phase = 0;
                end else begin
                    m_cnt++;
                    if (m_cnt == OVS) begin
                        m_cnt = 0;
                        if (ln) m_anyhi = 1;
                        if (m_phase == 2) begin
                            if (ln) m_bits = m_bits | (1 << m_idx);
                            m_idx++;
                            if (m_idx == 5 + char_len) m_phase = par_en ? 3 : 4;
                        end else if (m_phase == 3) begin
                            m_pbit = ln; m_phase = 4;
                        end else begin
                            brk = !m_anyhi;
                            done = 1;
                            nd = brk ? 8'h00 : m_bits[7:0];
                            nfe = !ln;
                            npe = par_en && !brk &&
                                  (m_pbit != (($countones(m_bits) % 2 == 1) ^ par_odd));
                            m_phase = brk ? 5 : 0;
                        end
                    end
                end
            end
            if (!act) m_ready = 0;
            else if (done) begin
                m_ov = m_ready && !rd; m_ready = 1;
                m_data = nd; m_pe = npe; m_fe = nfe;
            end else if (rd) m_ready = 0;
            if (tick) m_prev = ln;
            m_sync = {m_sync[SYNC-2:0], rxd};
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // tick generation and per-clock comparison
    always @(negedge clk) begin
        tick <= (tcnt == TDIV - 1);
        tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
        if (rst_n) begin
            chk(rx_ready == m_ready, "R8 ready", rx_ready, m_ready);
            chk(rx_data == m_data, "R3 data", rx_data, m_data);
            chk(err_parity == m_pe, "R5 parity flag", err_parity, m_pe);
            chk(err_frame == m_fe, "R6 frame flag", err_frame, m_fe);
            chk(err_overrun == m_ov, "R9 overrun flag", err_overrun, m_ov);
            if (rx_ready && !rdy_prev) rises++;
            rdy_prev = rx_ready;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic bit_out(input logic v);
        rxd = v;
        repeat (OVS * TDIV) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input bit flip, input bit stop);
        logic p;
        p = 1'b0;
        bit_out(1'b0);
        for (int i = 0; i < nb; i++) begin
            bit_out(d[i]);
            p = p ^ d[i];
        end
        if (par_en) bit_out(p ^ par_odd ^ flip);
        bit_out(stop);
        bit_out(1'b1);
    endtask

    task automatic do_read();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        chk(rx_ready == 1'b0, "R10 ready after read", rx_ready, 0);
    endtask

    initial begin
        int r0;
        repeat (5) @(negedge clk);
        chk(rx_ready == 0 && rx_data == 0 && err_frame == 0 && err_overrun == 0,
            "R1 reset state", {rx_ready, rx_data}, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R3: 8 data bits, no parity
        send(8'hA5, 8, 0, 1);
        chk(rx_ready && rx_data == 8'hA5 && !err_frame && !err_parity, "R3 8N1 char", rx_data, 8'hA5);
        do_read();

        // R4: 5-bit character, upper bits zero
        char_len = 2'd0;
        send(8'hFF, 5, 0, 1);
        chk(rx_data == 8'h1F, "R4 5-bit zero fill", rx_data, 8'h1F);
        do_read();
        char_len = 2'd2;
        send(8'h6B, 7, 0, 1);
        chk(rx_data == 8'h6B, "R4 7-bit char", rx_data, 8'h6B);
        do_read();

        // R5: even and odd parity, good and bad
        char_len = 2'd3; par_en = 1; par_odd = 0;
        send(8'h37, 8, 0, 1);
        chk(!err_parity && rx_data == 8'h37, "R5 even parity good", err_parity, 0);
        do_read();
        send(8'h37, 8, 1, 1);
        chk(err_parity == 1, "R5 even parity bad", err_parity, 1);
        do_read();
        par_odd = 1;
        send(8'hC1, 8, 0, 1);
        chk(!err_parity, "R5 odd parity good", err_parity, 0);
        do_read();
        send(8'hC1, 8, 1, 1);
        chk(err_parity == 1, "R5 odd parity bad", err_parity, 1);
        do_read();
        par_en = 0; par_odd = 0;

        // R6: low stop bit
        send(8'h55, 8, 0, 0);
        chk(err_frame == 1 && rx_data == 8'h55, "R6 framing error", rx_data, 8'h55);
        do_read();

        // R2: false start shorter than half a bit
        r0 = rises;
        rxd = 1'b0;
        repeat (3 * TDIV) @(negedge clk);
        bit_out(1'b1); bit_out(1'b1);
        chk(rises == r0 && !rx_ready, "R2 false start ignored", rises - r0, 0);

        // R7: break of thirteen bit times
        r0 = rises;
        for (int i = 0; i < 13; i++) bit_out(1'b0);
        chk(rises == r0 + 1, "R7 single break char", rises - r0, 1);
        chk(rx_data == 0 && err_frame && !err_parity, "R7 break content", {rx_data, err_frame}, 1);
        do_read();
        bit_out(1'b1);
        send(8'h5A, 8, 0, 1);
        chk(rx_data == 8'h5A && !err_frame, "R7 recovery after break", rx_data, 8'h5A);
        do_read();

        // R9: overrun
        send(8'h11, 8, 0, 1);
        send(8'h22, 8, 0, 1);
        chk(err_overrun && rx_data == 8'h22, "R9 overrun overwrite", rx_data, 8'h22);
        do_read();
        send(8'h33, 8, 0, 1);
        chk(!err_overrun, "R9 overrun cleared", err_overrun, 0);
        do_read();

        // R1: carrier lost and enable dropped
        r0 = rises;
        dcd_n = 1'b1;
        send(8'h44, 8, 0, 1);
        chk(rises == r0 && !rx_ready, "R1 no carrier", rises - r0, 0);
        dcd_n = 1'b0;
        bit_out(1'b1);
        send(8'h66, 8, 0, 1);
        chk(rx_ready == 1, "R1 ready before disable", rx_ready, 1);
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(rx_ready == 0, "R1 disable clears ready", rx_ready, 0);
        rx_en = 1'b1;
        repeat (20) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule